// File: doc/BRIEF.md
# Class-Compressed Table-Driven DFA Byte Scanner

The scanner walks a byte stream through a deterministic finite automaton held entirely in run-time-writable tables. A first stage folds every byte value into a small input-class code through a 256-entry class map, so bytes the automaton never distinguishes share one column. A second stage adds the class code to a per-state row offset and reads one slot of a single packed transition array. Each slot records both a next state and the state that owns the slot. When the owner differs from the current state, the per-state fallback next state is used instead. Only the transitions that differ from a state's fallback therefore need slots, and rows of different states can interleave in the array.

One byte is consumed every clock with no stalls, whatever the tables or the data. A pipeline controller with two named states, `PIPE_IDLE` (no symbol in the class stage) and `PIPE_BUSY` (a symbol waits for its transition lookup), runs the pipeline. It moves IDLE to BUSY when a byte arrives, BUSY to BUSY on back-to-back bytes, BUSY to IDLE on a gap, and any state to IDLE on a synchronous clear. Table writes are taken only in `PIPE_IDLE` with no byte on the input. The write port selects one of four tables. The automaton state is presented on an output, and a one-cycle match flag reports each step that lands in an accepting state.

Top module: `class_dfa_scan`

## Requirements
- R1: After reset the automaton state output is 0, match is low, and all table entries read as zero.
- R2: A byte is translated to the class code stored at that byte's address in the class map, written with wr_sel=0 and the class in wr_data bits [CW-1:0].
- R3: The slot index is (row offset of the current state + class code) modulo PACK_DEPTH. If that slot's owner field equals the current state, the next state is the slot's next-state field. Row offsets are written with wr_sel=1, addressed by state, value in wr_data[PW-1:0]. Slots are written with wr_sel=2, addressed by index, next state in wr_data[SW-1:0] and owner in wr_data[2*SW-1:SW].
- R4: If the owner field differs from the current state, the next state is the state's fallback. Fallbacks are written with wr_sel=3, addressed by state, fallback in wr_data[SW-1:0] and the accepting flag of that state in wr_data[SW].
- R5: A byte sampled with in_valid at clock edge k updates the state output at edge k+1. Bytes may arrive on every edge. With no byte in flight, the state holds.
- R6: match is high for the one cycle after each edge at which the automaton steps into a state whose accepting flag is set, and low otherwise.
- R7: A write is ignored when in_valid is high in the same cycle, or when a byte was sampled at the previous edge.
- R8: clr at an edge sets the state to 0, clears match, and discards both the byte sampled in that cycle and any byte in flight.
- R9: Rewriting all tables between scans changes the automaton, and later bytes follow the new tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous return to state 0 |
| in_valid | input | 1 | in_byte carries a symbol this cycle |
| in_byte | input | 8 | Input symbol |
| wr_en | input | 1 | Table write request |
| wr_sel | input | 2 | Table select: 0 class map, 1 row offset, 2 packed slot, 3 fallback/accept |
| wr_addr | input | ADDR_W (8) | Byte, state or slot index |
| wr_data | input | DATA_W (16) | Write value, fields per table |
| dfa_state | output | SW (3) | Current automaton state |
| match | output | 1 | Step landed in an accepting state |

## Verification
Two table sets are used. In the first, each state owns the slots of two classes and falls back on the other two, because rows overlap by two slots. In the second, row offsets are scattered and ownership is sparse. Each set is driven with a stream that covers all 256 byte values, with periodic gaps. Every cycle is compared against an arithmetic model, so slot hits (R3) are told apart from fallbacks (R4), and the one-edge latency can be seen against the hold behaviour. Directed sequences cover clear in the middle of a stream, with a byte presented and another in flight, and writes tried both alongside a byte and one cycle after one. Each rejected write is chosen so that it would change the next observed state if it were taken.

// File: rtl/cdfa_pkg.sv
package cdfa_pkg;

    typedef enum logic [1:0] {
        SEL_CLASS   = 2'd0,
        SEL_BASE    = 2'd1,
        SEL_ENTRY   = 2'd2,
        SEL_DEFAULT = 2'd3
    } tbl_sel_e;

    typedef enum logic {
        PIPE_IDLE = 1'b0,
        PIPE_BUSY = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/cdfa_ctrl.sv
module cdfa_ctrl
    import cdfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_valid,
    input  logic wr_en,
    output logic busy,
    output logic step,
    output logic wr_ok
);

    pipe_state_e cur_q;
    pipe_state_e nxt;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PIPE_IDLE: nxt = in_valid ? PIPE_BUSY : PIPE_IDLE;
            PIPE_BUSY: nxt = in_valid ? PIPE_BUSY : PIPE_IDLE;
            default:   nxt = PIPE_IDLE;
        endcase
        if (clr) nxt = PIPE_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= PIPE_IDLE;
        else        cur_q <= nxt;
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        step  = 1'b0;
        wr_ok = 1'b0;
        unique case (cur_q)
            PIPE_IDLE: wr_ok = wr_en && !in_valid;
            PIPE_BUSY: begin
                busy = 1'b1;
                step = !clr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cdfa_class_map.sv
module cdfa_class_map #(
    parameter int CW     = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        rbyte,
    output logic [CW-1:0]     cls_q
);

    localparam int ENTRIES = 256;

    logic [CW-1:0] map_mem [ENTRIES];
    wire unused_wbits = ^{wdata[DATA_W-1:CW], waddr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) map_mem[i] <= '0;
            cls_q <= '0;
        end else begin
            if (we) map_mem[waddr[7:0]] <= wdata[CW-1:0];
            cls_q <= map_mem[rbyte];
        end
    end

endmodule

// File: rtl/cdfa_trans_table.sv
module cdfa_trans_table
    import cdfa_pkg::*;
#(
    parameter int NUM_STATES = 8,
    parameter int NUM_CLASSES = 4,
    parameter int PACK_DEPTH = 16,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [1:0]                    wsel,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [$clog2(NUM_STATES)-1:0] cur_state,
    input  logic [$clog2(NUM_CLASSES)-1:0] cls,
    output logic [$clog2(NUM_STATES)-1:0] next_state,
    output logic                          next_accept
);

    localparam int SW = $clog2(NUM_STATES);
    localparam int PW = $clog2(PACK_DEPTH);

    logic [PW-1:0] base_mem [NUM_STATES];
    logic [SW-1:0] dflt_mem [NUM_STATES];
    logic          acc_mem  [NUM_STATES];
    logic [SW-1:0] nxt_mem  [PACK_DEPTH];
    logic [SW-1:0] own_mem  [PACK_DEPTH];

    wire unused_wbits = ^wdata[DATA_W-1:2*SW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STATES; s++) begin
                base_mem[s] <= '0;
                dflt_mem[s] <= '0;
                acc_mem[s]  <= 1'b0;
            end
            for (int e = 0; e < PACK_DEPTH; e++) begin
                nxt_mem[e] <= '0;
                own_mem[e] <= '0;
            end
        end else if (we) begin
            unique case (tbl_sel_e'(wsel))
                SEL_BASE:
                    if (waddr < ADDR_W'(NUM_STATES))
                        base_mem[waddr[SW-1:0]] <= wdata[PW-1:0];
                SEL_ENTRY:
                    if (waddr < ADDR_W'(PACK_DEPTH)) begin
                        nxt_mem[waddr[PW-1:0]] <= wdata[SW-1:0];
                        own_mem[waddr[PW-1:0]] <= wdata[2*SW-1:SW];
                    end
                SEL_DEFAULT:
                    if (waddr < ADDR_W'(NUM_STATES)) begin
                        dflt_mem[waddr[SW-1:0]] <= wdata[SW-1:0];
                        acc_mem[waddr[SW-1:0]]  <= wdata[SW];
                    end
                default: ;
            endcase
        end
    end

    logic [PW-1:0] slot;
    logic          owned;

    always_comb begin
        slot        = base_mem[cur_state] + PW'(cls);
        owned       = (own_mem[slot] == cur_state);
        next_state  = owned ? nxt_mem[slot] : dflt_mem[cur_state];
        next_accept = acc_mem[next_state];
    end

endmodule

// File: rtl/class_dfa_scan.sv
module class_dfa_scan
    import cdfa_pkg::*;
#(
    parameter int NUM_STATES  = 8,
    parameter int NUM_CLASSES = 4,
    parameter int PACK_DEPTH  = 16,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [$clog2(NUM_STATES)-1:0] dfa_state,
    output logic                          match
);

    localparam int SW = $clog2(NUM_STATES);
    localparam int CW = $clog2(NUM_CLASSES);

    logic          pipe_busy;
    logic          pipe_step;
    logic          wr_ok;
    logic [CW-1:0] cls_q;
    logic [SW-1:0] nxt_state;
    logic          nxt_accept;
    logic          map_we;
    logic          tbl_we;

    assign map_we = wr_ok && (tbl_sel_e'(wr_sel) == SEL_CLASS);
    assign tbl_we = wr_ok && (tbl_sel_e'(wr_sel) != SEL_CLASS);

    cdfa_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .wr_en    (wr_en),
        .busy     (pipe_busy),
        .step     (pipe_step),
        .wr_ok    (wr_ok)
    );

    cdfa_class_map #(.CW(CW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rbyte (in_byte),
        .cls_q (cls_q)
    );

    cdfa_trans_table #(
        .NUM_STATES (NUM_STATES),
        .NUM_CLASSES(NUM_CLASSES),
        .PACK_DEPTH (PACK_DEPTH),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (tbl_we),
        .wsel       (wr_sel),
        .waddr      (wr_addr),
        .wdata      (wr_data),
        .cur_state  (dfa_state),
        .cls        (cls_q),
        .next_state (nxt_state),
        .next_accept(nxt_accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dfa_state <= '0;
            match     <= 1'b0;
        end else if (clr) begin
            dfa_state <= '0;
            match     <= 1'b0;
        end else if (pipe_step) begin
            dfa_state <= nxt_state;
            match     <= nxt_accept;
        end else begin
            match     <= 1'b0;
        end
    end

endmodule

// File: rtl/cdfa_scan_checker.sv
module cdfa_scan_checker #(
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          in_valid,
    input logic          busy,
    input logic [SW-1:0] dfa_state,
    input logic          match
);

    // R6: a match only follows an edge that performed a step
    assert_match_after_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(busy) && !$past(clr)));

    // R5: with no symbol in flight the state holds
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> $stable(dfa_state));

    // R5: a gap empties the class stage
    assert_gap_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> !busy);

    // R7: an accepted byte occupies the pipeline, which blocks writes
    assert_byte_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> busy);

    // R8: clear returns to state 0 with match low
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dfa_state == '0 && !match && !busy));

endmodule

bind class_dfa_scan cdfa_scan_checker #(.SW($clog2(NUM_STATES))) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .busy     (pipe_busy),
    .dfa_state(dfa_state),
    .match    (match)
);

// File: tb/class_dfa_scan_bench.sv
module class_dfa_scan_bench;

    localparam int ST = 8;
    localparam int CL = 4;
    localparam int DP = 16;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [SW-1:0] dfa_state;
    logic          match;

    always #10 clk = ~clk;

    class_dfa_scan #(.NUM_STATES(ST), .NUM_CLASSES(CL), .PACK_DEPTH(DP),
                     .DATA_W(DW), .ADDR_W(AW)) u_class_dfa_scan (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .dfa_state(dfa_state), .match(match)
    );

    int checks = 0;
    int errors = 0;

    int m_cls [256];
    int m_base[ST];
    int m_dflt[ST];
    int m_acc [ST];
    int m_own [DP];
    int m_nxt [DP];

    int mstate = 0;
    bit p1v = 0, p2v = 0;
    int p1b = 0, p2b = 0;
    bit last_v = 0, last_c = 0;

    function automatic int slot_of(int s, int b);
        return (m_base[s] + m_cls[b]) % DP;
    endfunction

    function automatic bit hit_of(int s, int b);
        return m_own[slot_of(s, b)] == s;
    endfunction

    function automatic int step_of(int s, int b);
        return hit_of(s, b) ? m_nxt[slot_of(s, b)] : m_dflt[s];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: check the result of the edge just passed, then drive the next
    task automatic cyc(bit v, int b, bit c, bit we, int sel, int addr, int data);
        string tag;
        int    em;
        @(negedge clk);
        em  = 0;
        tag = last_c ? "R8" : "R5";
        if (p2v) begin
            tag    = hit_of(mstate, p2b) ? "R3 (R2,R5)" : "R4 (R2,R5)";
            mstate = step_of(mstate, p2b);
            em     = m_acc[mstate];
        end
        check(dfa_state == SW'(mstate), tag, dfa_state, mstate);
        check(match == em[0], "R6", match, em);
        p2v = p1v; p2b = p1b;
        p1v = v && !c; p1b = b;
        if (c) begin
            mstate = 0;
            p2v    = 0;
        end
        if (we && !v && !(last_v && !last_c)) begin
            case (sel)
                0: m_cls[addr] = data % CL;
                1: m_base[addr] = data % DP;
                2: begin m_nxt[addr] = data % 8; m_own[addr] = (data >> 3) % 8; end
                default: begin m_dflt[addr] = data % 8; m_acc[addr] = (data >> 3) % 2; end
            endcase
        end
        last_v   = v;
        last_c   = c;
        in_valid = v;
        in_byte  = 8'(b);
        clr      = c;
        wr_en    = we;
        wr_sel   = 2'(sel);
        wr_addr  = AW'(addr);
        wr_data  = DW'(data);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load_cfg(int which);
        for (int b = 0; b < 256; b++)
            cyc(0, 0, 0, 1, 0, b, which == 0 ? (b + (b >> 4)) % 4 : (b >> 3) % 4);
        for (int s = 0; s < ST; s++)
            cyc(0, 0, 0, 1, 1, s, which == 0 ? (2 * s) % DP : (5 * s + 3) % DP);
        for (int e = 0; e < DP; e++) begin
            int own, nx;
            own = which == 0 ? (e / 2) % 8 : (3 * e) % 8;
            nx  = which == 0 ? (3 * e + 1) % 8 : (5 * e + 2) % 8;
            cyc(0, 0, 0, 1, 2, e, (own << 3) | nx);
        end
        for (int s = 0; s < ST; s++) begin
            int df, ac;
            df = which == 0 ? (s + 5) % 8 : (3 * s) % 8;
            ac = which == 0 ? int'(s == 3 || s == 6) : int'(s % 3 == 2);
            cyc(0, 0, 0, 1, 3, s, (ac << 3) | df);
        end
        idle(1);
    endtask

    task automatic stream(int n, int mul);
        for (int i = 0; i < n; i++)
            cyc((i % 13) != 12, (i * mul + i / 256) % 256, 0, 0, 0, 0, 0);
        idle(2);
    endtask

    initial begin
        for (int b = 0; b < 256; b++) m_cls[b] = 0;
        for (int s = 0; s < ST; s++) begin m_base[s] = 0; m_dflt[s] = 0; m_acc[s] = 0; end
        for (int e = 0; e < DP; e++) begin m_own[e] = 0; m_nxt[e] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dfa_state == '0, "R1", dfa_state, 0);
        check(match == 1'b0, "R1", match, 0);
        // zeroed tables keep state 0 on any byte (R1)
        cyc(1, 8'h5a, 0, 0, 0, 0, 0);
        idle(3);
        check(dfa_state == '0, "R1", dfa_state, 0);

        load_cfg(0);
        stream(520, 157);

        // clear in the middle of a stream, with a byte in flight (R8)
        for (int i = 0; i < 6; i++) cyc(1, 17 * i + 3, 0, 0, 0, 0, 0);
        cyc(1, 200, 1, 0, 0, 0, 0);
        idle(2);
        check(dfa_state == '0, "R8", dfa_state, 0);

        // rejected writes (R7): one beside a byte, one while a byte is in flight
        cyc(1, 0, 0, 1, 0, 0, 2);
        cyc(0, 0, 0, 1, 2, 0, 7);
        idle(2);
        check(dfa_state == SW'(1), "R7", dfa_state, 1);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        idle(2);
        check(dfa_state == SW'(1), "R7", dfa_state, 1);

        // new tables between scans (R9)
        cyc(0, 0, 1, 0, 0, 0, 0);
        load_cfg(1);
        stream(520, 91);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(1, 8'h18, 0, 0, 0, 0, 0);
        idle(2);
        check(dfa_state == SW'(step_of(0, 8'h18)), "R9", dfa_state, step_of(0, 8'h18));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule